// File: doc/BRIEF.md
# Front-End Phase Sequencer

This block drives a daisy chain of front-end readout chips through one full measurement cycle. A start request first holds the chain in a global reset. Then the block waits for the bunch-train window and records during it. It then gives the chips a fixed conversion burst, and finally reads them out serially. All of this runs from a single 50 MHz core clock. The one shared chip clock changes rate with the phase. It ticks once per bunch crossing while recording, is held low during conversion, and runs at a slower rate during readout that software chooses.

Conversion is not ended by the chips. The block grants a fixed number of core-clock cycles on a clock-enable output, sized for the slowest chip. Downstream, that enable gates the core clock into the conversion clock line. Readout begins by launching a token into the first chip and ends when the token comes back from the last chip. A readout-clock timeout covers a broken chain. While readout runs, serial bits are taken only when the shared transmit-enable line is high. They are packed into bytes, and each finished byte is presented with a one-cycle strobe. The shared RAM-full line is the wired-OR of every chip. Any assertion is latched as a full condition and cuts acquisition short.

Top module: `fe_phase_seq`

## Requirements
- R1: `phase_o` reports the phase as 0 idle, 1 global reset, 2 armed, 3 acquisition, 4 conversion, 5 readout. Phases only advance in that order and return to idle from readout. All outputs are 0 after reset.
- R2: In idle, `start_i` moves the block to global reset. `glb_rst_o` is then high for exactly RST_CYC cycles, after which the block is armed.
- R3: When armed, the block enters acquisition on the first cycle `train_i` is high. In acquisition, `acq_ro_clk_o` starts low and toggles every ACQ_HALF core cycles, which is a 10-cycle period by default. Acquisition ends in the first cycle with `train_i` low or `ram_full_i` high.
- R4: In conversion, `conv_en_o` is high for exactly CONV_CLKS consecutive cycles and `acq_ro_clk_o` stays low. Readout follows.
- R5: In readout, `acq_ro_clk_o` starts low and toggles every `ro_half_i` core cycles. The legal range is 10 to 25, which gives 20 to 50 core cycles per bit.
- R6: `token_o` is high from the first readout cycle until the second rising edge of `acq_ro_clk_o` in that readout.
- R7: `token_back_i` high in readout returns the block to idle on the next cycle, with `done_o` high for that one cycle.
- R8: In the core cycle just before each readout rising edge of `acq_ro_clk_o`, `data_i` is taken as a bit if `tx_en_i` is high and is ignored otherwise. Bits fill a byte MSB first. Each eighth bit updates `byte_o` and pulses `byte_vld_o` for one cycle. A partial byte is dropped when readout ends.
- R9: `full_o` is set by any `ram_full_i` assertion outside idle and holds until the next accepted start.
- R10: If TIMEOUT_CLKS readout rising edges pass without `token_back_i`, the block goes to idle and sets `timeout_err_o`. The flag holds until the next accepted start. `token_back_i` takes priority in the same cycle.
- R11: `start_i` has no effect outside idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one measurement cycle |
| train_i | input | 1 | Bunch-train window |
| ram_full_i | input | 1 | Wired-OR RAM-full line from the chips |
| token_back_i | input | 1 | Token returned from the last chip |
| tx_en_i | input | 1 | Shared transmit-enable; data valid while high |
| data_i | input | 1 | Shared serial data line |
| ro_half_i | input | 5 | Readout clock half period in core cycles |
| phase_o | output | 3 | Current phase code |
| glb_rst_o | output | 1 | Global reset to the chips |
| acq_ro_clk_o | output | 1 | Shared acquisition/readout clock |
| conv_en_o | output | 1 | Conversion clock enable (gates the core clock) |
| token_o | output | 1 | Readout token into the first chip |
| byte_o | output | 8 | Last assembled readout byte |
| byte_vld_o | output | 1 | One-cycle strobe for a new byte |
| full_o | output | 1 | Latched RAM-full condition |
| timeout_err_o | output | 1 | Token-return timeout flag |
| done_o | output | 1 | One-cycle pulse on a clean readout finish |

## Verification
The assertions check several properties on every cycle. Global reset only ever starts from a start request. The chip clock is never high outside acquisition or readout, or together with the conversion enable. The token only rises on entry to readout. A byte strobe never lasts two cycles. The full and timeout flags behave as sticky flags. Other behaviour needs the bench's scenarios: exact phase lengths, clock periods for several readout rates, byte contents under gated transmit-enable, RAM-full cutting acquisition short, a token returning while the launch token is still high, and the timeout path.

// File: rtl/fe_seq_pkg.sv
package fe_seq_pkg;
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_GRST = 3'd1,
        PH_ARM  = 3'd2,
        PH_ACQ  = 3'd3,
        PH_CONV = 3'd4,
        PH_RO   = 3'd5
    } phase_e;
endpackage

// File: rtl/fe_rate_gen.sv
module fe_rate_gen #(
    parameter int HALF_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [HALF_W-1:0] half_i,
    output logic              clk_o,
    output logic              rise_o
);
    typedef struct packed {
        logic [HALF_W-1:0] cnt;
        logic              lvl;
    } rg_t;

    rg_t r_q, r_d;
    logic wrap;

    assign wrap   = (r_q.cnt >= (half_i - HALF_W'(1)));
    assign rise_o = wrap && !r_q.lvl;
    assign clk_o  = r_q.lvl;

    always_comb begin
        r_d = r_q;
        if (!run_i) begin
            r_d.cnt = '0;
            r_d.lvl = 1'b0;
        end else if (wrap) begin
            r_d.cnt = '0;
            r_d.lvl = !r_q.lvl;
        end else begin
            r_d.cnt = r_q.cnt + HALF_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/fe_byte_pack.sv
module fe_byte_pack #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              take_i,
    input  logic              bit_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              vld_o
);
    localparam int CW = $clog2(BYTE_W);

    typedef struct packed {
        logic [BYTE_W-2:0] sh;
        logic [CW-1:0]     cnt;
        logic [BYTE_W-1:0] dat;
        logic              vld;
    } bp_t;

    bp_t b_q, b_d;

    always_comb begin
        b_d     = b_q;
        b_d.vld = 1'b0;
        if (clr_i) begin
            b_d.sh  = '0;
            b_d.cnt = '0;
        end else if (take_i) begin
            if (b_q.cnt == CW'(BYTE_W-1)) begin
                b_d.dat = {b_q.sh, bit_i};
                b_d.vld = 1'b1;
                b_d.cnt = '0;
            end else begin
                b_d.sh  = {b_q.sh[BYTE_W-3:0], bit_i};
                b_d.cnt = b_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign byte_o = b_q.dat;
    assign vld_o  = b_q.vld;

    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |=> !vld_o); // R8
endmodule

// File: rtl/fe_phase_seq.sv
module fe_phase_seq
    import fe_seq_pkg::*;
#(
    parameter int ACQ_HALF     = 5,
    parameter int RST_CYC      = 4,
    parameter int CONV_CLKS    = 16,
    parameter int TIMEOUT_CLKS = 64,
    parameter int HALF_W       = 5,
    parameter int BYTE_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              train_i,
    input  logic              ram_full_i,
    input  logic              token_back_i,
    input  logic              tx_en_i,
    input  logic              data_i,
    input  logic [HALF_W-1:0] ro_half_i,
    output logic [2:0]        phase_o,
    output logic              glb_rst_o,
    output logic              acq_ro_clk_o,
    output logic              conv_en_o,
    output logic              token_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_vld_o,
    output logic              full_o,
    output logic              timeout_err_o,
    output logic              done_o
);
    localparam int PC_MAX = (CONV_CLKS > RST_CYC) ? CONV_CLKS : RST_CYC;
    localparam int PC_W   = $clog2(PC_MAX + 1);
    localparam int EW     = $clog2(TIMEOUT_CLKS + 1);

    typedef struct packed {
        phase_e        ph;
        logic [PC_W-1:0] pc;
        logic [EW-1:0]   edges;
        logic          full;
        logic          err;
        logic          done;
    } seq_t;

    seq_t s_q, s_d;

    logic              rise_raw;
    logic              run;
    logic [HALF_W-1:0] half_sel;

    assign half_sel = (s_q.ph == PH_ACQ) ? HALF_W'(ACQ_HALF) : ro_half_i;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.ph != PH_IDLE && ram_full_i) s_d.full = 1'b1;
        unique case (s_q.ph)
            PH_IDLE: if (start_i) begin
                s_d.ph   = PH_GRST;
                s_d.pc   = '0;
                s_d.err  = 1'b0;
                s_d.full = 1'b0;
            end
            PH_GRST: if (s_q.pc == PC_W'(RST_CYC-1)) begin
                s_d.ph = PH_ARM;
                s_d.pc = '0;
            end else begin
                s_d.pc = s_q.pc + PC_W'(1);
            end
            PH_ARM: if (train_i) s_d.ph = PH_ACQ;
            PH_ACQ: if (!train_i || ram_full_i) begin
                s_d.ph = PH_CONV;
                s_d.pc = '0;
            end
            PH_CONV: if (s_q.pc == PC_W'(CONV_CLKS-1)) begin
                s_d.ph = PH_RO;
                s_d.pc = '0;
            end else begin
                s_d.pc = s_q.pc + PC_W'(1);
            end
            PH_RO: if (token_back_i) begin
                s_d.ph   = PH_IDLE;
                s_d.done = 1'b1;
            end else if (rise_raw && s_q.edges == EW'(TIMEOUT_CLKS-1)) begin
                s_d.ph  = PH_IDLE;
                s_d.err = 1'b1;
            end else if (rise_raw) begin
                s_d.edges = s_q.edges + EW'(1);
            end
            default: s_d.ph = PH_IDLE;
        endcase
        if (s_q.ph != PH_RO) s_d.edges = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ph: PH_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign run = (s_q.ph == PH_ACQ || s_q.ph == PH_RO) && (s_d.ph == s_q.ph);

    fe_rate_gen #(.HALF_W(HALF_W)) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .half_i (half_sel),
        .clk_o  (acq_ro_clk_o),
        .rise_o (rise_raw)
    );

    fe_byte_pack #(.BYTE_W(BYTE_W)) u_pack (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (s_q.ph != PH_RO),
        .take_i (s_q.ph == PH_RO && run && rise_raw && tx_en_i),
        .bit_i  (data_i),
        .byte_o (byte_o),
        .vld_o  (byte_vld_o)
    );

    assign phase_o       = s_q.ph;
    assign glb_rst_o     = (s_q.ph == PH_GRST);
    assign conv_en_o     = (s_q.ph == PH_CONV);
    assign token_o       = (s_q.ph == PH_RO) && (s_q.edges < EW'(2));
    assign full_o        = s_q.full;
    assign timeout_err_o = s_q.err;
    assign done_o        = s_q.done;

    AST_GRST_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(glb_rst_o) |-> $past(start_i)); // R2
    AST_CLK_ACTIVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        acq_ro_clk_o |-> (phase_o == 3'd3 || phase_o == 3'd5)); // R3
    AST_CONV_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        conv_en_o |-> !acq_ro_clk_o); // R4
    AST_TOKEN_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(token_o) |-> $past(conv_en_o)); // R6
    AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !(phase_o == 3'd0 && start_i)) |=> full_o); // R9
    AST_ERR_ONLY_FROM_RO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err_o) |-> (phase_o == 3'd0 && $past(phase_o) == 3'd5)); // R10
endmodule

// File: tb/tb_fe_phase_seq.sv
module tb_fe_phase_seq;
    localparam int ACQ_H = 5, RST_C = 4, CONV_C = 16, TO_C = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 0, train_i = 0, ram_full_i = 0, token_back_i = 0;
    logic       tx_en_i = 0, data_i = 0;
    logic [4:0] ro_half_i = 5'd10;
    logic [2:0] phase_o;
    logic       glb_rst_o, acq_ro_clk_o, conv_en_o, token_o, byte_vld_o;
    logic       full_o, timeout_err_o, done_o;
    logic [7:0] byte_o;

    always #2 clk = !clk;

    fe_phase_seq dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .train_i(train_i),
        .ram_full_i(ram_full_i), .token_back_i(token_back_i), .tx_en_i(tx_en_i),
        .data_i(data_i), .ro_half_i(ro_half_i), .phase_o(phase_o),
        .glb_rst_o(glb_rst_o), .acq_ro_clk_o(acq_ro_clk_o), .conv_en_o(conv_en_o),
        .token_o(token_o), .byte_o(byte_o), .byte_vld_o(byte_vld_o),
        .full_o(full_o), .timeout_err_o(timeout_err_o), .done_o(done_o)
    );

    int vectors = 0, errors = 0;
    bit finished = 0;

    // behavioural reference state
    int m_ph, m_pc, m_edges, m_rc, m_bits, m_sh, m_byte;
    bit m_lvl, m_vld, m_full, m_err, m_done;
    int n_ph, n_pc, n_edges, h;
    bit rise, stay;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_pc = 0; m_edges = 0; m_rc = 0; m_bits = 0; m_sh = 0;
            m_byte = 0; m_lvl = 0; m_vld = 0; m_full = 0; m_err = 0; m_done = 0;
        end else begin
            h = (m_ph == 3) ? ACQ_H : int'(ro_half_i);
            rise = (m_ph == 3 || m_ph == 5) && !m_lvl && (m_rc >= h - 1);
            n_ph = m_ph; n_pc = m_pc; n_edges = m_edges; m_done = 0;
            if (m_ph != 0 && ram_full_i) m_full = 1;
            case (m_ph)
                0: if (start_i) begin n_ph = 1; n_pc = 0; m_err = 0; m_full = 0; end
                1: if (m_pc == RST_C - 1) begin n_ph = 2; n_pc = 0; end else n_pc = m_pc + 1;
                2: if (train_i) n_ph = 3;
                3: if (!train_i || ram_full_i) begin n_ph = 4; n_pc = 0; end
                4: if (m_pc == CONV_C - 1) begin n_ph = 5; n_pc = 0; end else n_pc = m_pc + 1;
                5: if (token_back_i) begin n_ph = 0; m_done = 1; end
                   else if (rise && m_edges == TO_C - 1) begin n_ph = 0; m_err = 1; end
                   else if (rise) n_edges = m_edges + 1;
                default: n_ph = 0;
            endcase
            if (m_ph != 5) n_edges = 0;
            stay = (n_ph == m_ph);
            m_vld = 0;
            if (m_ph != 5) begin
                m_bits = 0; m_sh = 0;
            end else if (rise && stay && tx_en_i) begin
                if (m_bits == 7) begin
                    m_byte = ((m_sh << 1) | int'(data_i)) & 8'hff; m_vld = 1; m_bits = 0;
                end else begin
                    m_sh = ((m_sh << 1) | int'(data_i)) & 8'h7f; m_bits = m_bits + 1;
                end
            end
            if ((m_ph == 3 || m_ph == 5) && stay) begin
                if (m_rc >= h - 1) begin m_rc = 0; m_lvl = !m_lvl; end
                else m_rc = m_rc + 1;
            end else begin
                m_rc = 0; m_lvl = 0;
            end
            m_ph = n_ph; m_pc = n_pc; m_edges = n_edges;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            vectors++;
            chk("R1 phase", int'(phase_o), m_ph);
            chk("R2 glb_rst", int'(glb_rst_o), int'(m_ph == 1));
            chk((m_ph == 5) ? "R5 ro clock" : "R3 acq clock", int'(acq_ro_clk_o), int'(m_lvl));
            chk("R4 conv_en", int'(conv_en_o), int'(m_ph == 4));
            chk("R6 token", int'(token_o), int'(m_ph == 5 && m_edges < 2));
            chk("R7 done", int'(done_o), int'(m_done));
            chk("R8 byte_vld", int'(byte_vld_o), int'(m_vld));
            chk("R8 byte", int'(byte_o), m_byte);
            chk("R9 full", int'(full_o), int'(m_full));
            chk("R10 timeout", int'(timeout_err_o), int'(m_err));
        end
    end

    logic [15:0] lfsr = 16'hACE1;

    // one full measurement cycle; full_at < 0 means no RAM-full, tok_after < 0 means no token return
    task automatic run_cycle(input int half, input int train_len, input int full_at, input int tok_after);
        int rises = 0;
        int k = 0;
        bit prev = 0;
        @(negedge clk); ro_half_i = 5'(half); start_i = 1;
        @(negedge clk); start_i = 0;
        while (phase_o != 3'd2) @(negedge clk);
        repeat (3) @(negedge clk);
        train_i = 1;
        for (int i = 0; i < train_len; i++) begin
            @(negedge clk);
            start_i = (i == 4);          // R11: ignored while busy
            ram_full_i = (i == full_at);
        end
        start_i = 0; ram_full_i = 0;
        @(negedge clk); train_i = 0;
        while (phase_o != 3'd5) @(negedge clk);
        while (phase_o == 3'd5) begin
            if (acq_ro_clk_o && !prev) rises++;
            prev = acq_ro_clk_o;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            data_i = lfsr[0];
            tx_en_i = ((k / 150) % 3) != 2;
            token_back_i = (tok_after >= 0 && rises == tok_after && !token_back_i);
            k++;
            @(negedge clk);
        end
        token_back_i = 0; tx_en_i = 0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        vectors++;
        chk("R1 reset phase", int'(phase_o), 0);
        chk("R1 reset outputs", int'({glb_rst_o, acq_ro_clk_o, conv_en_o, token_o,
            byte_vld_o, full_o, timeout_err_o, done_o}), 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        run_cycle(10, 63, -1, 30);   // R3 R5 R7 R8 normal cycle
        run_cycle(25, 60, 17, 12);   // R9 RAM-full ends acquisition early
        run_cycle(10, 30, -1, -1);   // R10 timeout
        run_cycle(13, 40, -1, 1);    // R6 R7 token back while token high
        run_cycle(20, 25, 3, 18);    // R9 R10 flags cleared by new start
        repeat (10) @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL R1 watchdog: actual phase=%0d expected=0", phase_o);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule